// File: doc/BRIEF.md
# Virtual Link Frame Classifier

This block sorts received Ethernet frames into virtual links using a small rule table that is held as static configuration. Each frame header comes in already parsed, as four fields: destination MAC, VLAN ID, VLAN priority and ingress port number. The header arrives with a one-cycle strobe. Exactly one cycle later the block returns a verdict. The verdict says whether a rule hit and which rule won. It also says whether the frame is redirected at once to a port bitmap, or is handed on as a virtual link number to a later forwarding stage. A frame that hits nothing keeps the port bitmap from the ordinary L2 lookup, and that bitmap arrives alongside the header.

One global setting picks between two key formats. The exact format compares all four header fields against the rule. The marker format works differently. It masks the upper 32 MAC bits and compares them with a global marker. It then takes the low 16 MAC bits as the virtual link number and compares that, together with the ingress port, against the rule. A rule whose bitmap holds only the CPU port bit diverts matching traffic to the processor. Because a hit wins over the L2 lookup, such a rule hides any static forwarding entry for the same address and VLAN.

Control is a two-state machine. `ST_IDLE` means no result is pending. `ST_EMIT` means the result registers hold a fresh verdict and `res_valid` is high. The transitions are as follows. IDLE to EMIT happens on a header strobe. EMIT to EMIT happens on a back-to-back strobe. EMIT to IDLE happens when no strobe arrives. IDLE to IDLE happens while the header input stays quiet. Reset returns the machine to `ST_IDLE`.

Top module: `vl_classifier`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle in which `hdr_valid` is high, and low otherwise; back-to-back strobes give back-to-back results.
- R2: With `cfg_key_fmt` = 0 (exact format), a valid rule matches only when destination MAC, VLAN ID, VLAN priority and ingress port all equal the rule's fields; a difference in any single field is a miss.
- R3: With `cfg_key_fmt` = 1 (marker format), a valid rule matches when (`hdr_dmac[47:16]` AND `cfg_mark_mask`) equals `cfg_mark_value`, `hdr_dmac[15:0]` equals the rule's VL ID field, and the ingress port equals the rule's port; VLAN ID and priority are ignored.
- R4: A rule whose `cfg_rule_valid` bit is 0 never matches, in either format, even when all its fields equal the frame.
- R5: When several rules match, the lowest-numbered rule wins and its index appears on `res_idx`.
- R6: On a miss, `res_hit` = 0, `res_critical` = 0, `res_idx` = 0, `res_vlid` = 0 and `res_dest` equals the `l2_dest` presented with the header.
- R7: In the exact format, a hit on a rule with its critical bit 0 gives `res_critical` = 0, `res_vlid` = 0 and `res_dest` equal to the rule's destination bitmap (bit 4 alone means the CPU port, so the frame is trapped and the L2 bitmap is dropped).
- R8: In the exact format, a hit on a rule with its critical bit 1 gives `res_critical` = 1, `res_vlid` equal to the winning rule index (zero-extended) and `res_dest` = 0.
- R9: In the marker format, every hit gives `res_critical` = 1, `res_vlid` equal to the winning rule's VL ID field and `res_dest` = 0; the rule's critical bit has no effect.
- R10: During and right after reset, `res_valid`, `res_hit`, `res_critical`, `res_idx`, `res_vlid` and `res_dest` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_key_fmt | input | 1 | Global key format: 0 exact, 1 marker |
| cfg_mark_mask | input | 32 | Mask applied to MAC bits 47:16 in marker format |
| cfg_mark_value | input | 32 | Marker that the masked MAC bits must equal |
| cfg_rule_valid | input | NUM_RULES | Per-rule enable |
| cfg_rule_crit | input | NUM_RULES | Per-rule critical bit (exact format only) |
| cfg_rule_mac | input | NUM_RULES*48 | Per-rule destination MAC, rule k at bits 48k+47:48k |
| cfg_rule_vid | input | NUM_RULES*12 | Per-rule VLAN ID |
| cfg_rule_pcp | input | NUM_RULES*3 | Per-rule VLAN priority |
| cfg_rule_port | input | NUM_RULES*PORT_W | Per-rule ingress port number |
| cfg_rule_vlid | input | NUM_RULES*16 | Per-rule VL ID (marker format key and output) |
| cfg_rule_dest | input | NUM_RULES*NUM_PORTS | Per-rule destination port bitmap |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_dmac | input | 48 | Frame destination MAC |
| hdr_vid | input | 12 | Frame VLAN ID |
| hdr_pcp | input | 3 | Frame VLAN priority |
| hdr_port | input | PORT_W | Ingress port number |
| l2_dest | input | NUM_PORTS | Bitmap from the ordinary L2 lookup |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A rule matched |
| res_idx | output | IDX_W | Index of the winning rule |
| res_critical | output | 1 | Verdict is a VL handoff, not a direct redirect |
| res_vlid | output | 16 | Virtual link number handed on |
| res_dest | output | NUM_PORTS | Destination port bitmap |

## Verification
Each header field is varied alone against a trap rule. A comparator that dropped one field would then report a hit where a miss is expected, and the L2 bitmap would be lost. Disabled rules are all zero, so an all-zero frame and a marker frame with VL ID 0 would hit them if the valid bit were ignored. Two rules share one key in both formats, so a priority encoder that favoured the higher index would report rule 4 instead of rule 3. The marker tests set masked-off MAC bits and pass VLAN fields that match no rule. Those tests catch a mask applied the wrong way round and a format that wrongly falls back to the four-field compare. Handoff frames check that the VL ID comes from the rule index in one format and from the rule contents in the other, and a swapped source shows up as a wrong `res_vlid`.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int MAC_W  = 48;
    localparam int VID_W  = 12;
    localparam int PCP_W  = 3;
    localparam int VLID_W = 16;
    localparam int MARK_W = MAC_W - VLID_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vlc_state_e;

    typedef enum logic [0:0] {
        KEY_EXACT  = 1'b0,
        KEY_MARKER = 1'b1
    } key_fmt_e;

endpackage

// File: rtl/vlc_rule_match.sv
module vlc_rule_match
    import vlc_pkg::*;
#(
    parameter int PORT_W = 3
) (
    input  key_fmt_e            key_fmt,
    input  logic [MARK_W-1:0]   mark_mask,
    input  logic [MARK_W-1:0]   mark_value,
    input  logic                rule_valid,
    input  logic [MAC_W-1:0]    rule_mac,
    input  logic [VID_W-1:0]    rule_vid,
    input  logic [PCP_W-1:0]    rule_pcp,
    input  logic [PORT_W-1:0]   rule_port,
    input  logic [VLID_W-1:0]   rule_vlid,
    input  logic [MAC_W-1:0]    hdr_dmac,
    input  logic [VID_W-1:0]    hdr_vid,
    input  logic [PCP_W-1:0]    hdr_pcp,
    input  logic [PORT_W-1:0]   hdr_port,
    output logic                match_o
);

    logic port_eq;
    logic exact_hit;
    logic marker_hit;

    always_comb begin
        port_eq    = (hdr_port == rule_port);
        exact_hit  = (hdr_dmac == rule_mac) && (hdr_vid == rule_vid) &&
                     (hdr_pcp == rule_pcp) && port_eq;
        marker_hit = ((hdr_dmac[MAC_W-1:VLID_W] & mark_mask) == mark_value) &&
                     (hdr_dmac[VLID_W-1:0] == rule_vlid) && port_eq;
        match_o    = rule_valid &&
                     ((key_fmt == KEY_MARKER) ? marker_hit : exact_hit);
    end

endmodule

// File: rtl/vlc_prio_pick.sv
module vlc_prio_pick #(
    parameter int NUM_RULES = 16,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_RULES-1:0] match_i,
    output logic [NUM_RULES-1:0] grant_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 any_o
);

    // Scan from the top down so the lowest matching index is the last written.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int k = NUM_RULES - 1; k >= 0; k--) begin
            if (match_i[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                idx_o      = IDX_W'(k);
                any_o      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
    import vlc_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  key_fmt_e             key_fmt,
    input  logic                 any_hit,
    input  logic [IDX_W-1:0]     win_idx,
    input  logic                 win_crit,
    input  logic [VLID_W-1:0]    win_vlid,
    input  logic [NUM_PORTS-1:0] win_dest,
    input  logic [NUM_PORTS-1:0] l2_dest,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_idx,
    output logic                 res_critical,
    output logic [VLID_W-1:0]    res_vlid,
    output logic [NUM_PORTS-1:0] res_dest
);

    vlc_state_e state_q, state_d;

    logic                 nx_critical;
    logic [VLID_W-1:0]    nx_vlid;
    logic [NUM_PORTS-1:0] nx_dest;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = hdr_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = hdr_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Verdict selection for the frame being strobed in.
    always_comb begin
        nx_critical = 1'b0;
        nx_vlid     = '0;
        nx_dest     = l2_dest;
        if (any_hit) begin
            if (key_fmt == KEY_MARKER) begin
                nx_critical = 1'b1;
                nx_vlid     = win_vlid;
                nx_dest     = '0;
            end else if (win_crit) begin
                nx_critical = 1'b1;
                nx_vlid     = {{(VLID_W-IDX_W){1'b0}}, win_idx};
                nx_dest     = '0;
            end else begin
                nx_dest     = win_dest;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit      <= 1'b0;
            res_idx      <= '0;
            res_critical <= 1'b0;
            res_vlid     <= '0;
            res_dest     <= '0;
        end else if (hdr_valid) begin
            res_hit      <= any_hit;
            res_idx      <= any_hit ? win_idx : '0;
            res_critical <= nx_critical;
            res_vlid     <= nx_vlid;
            res_dest     <= nx_dest;
        end
    end

    always_comb res_valid = (state_q == ST_EMIT);

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);
    assert_miss_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_dest == $past(l2_dest) &&
                                     res_vlid == '0 && !res_critical));
    assert_redirect_no_vlid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && !res_critical) |-> (res_vlid == '0));
    assert_index_vlid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && res_critical && key_fmt == KEY_EXACT) |->
        (res_vlid == {{(VLID_W-IDX_W){1'b0}}, res_idx} && res_dest == '0));
    assert_marker_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && key_fmt == KEY_MARKER) |->
        (res_critical && res_dest == '0));

endmodule

// File: rtl/vl_classifier.sv
module vl_classifier
    import vlc_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int NUM_PORTS = 5,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_key_fmt,
    input  logic [31:0]                    cfg_mark_mask,
    input  logic [31:0]                    cfg_mark_value,
    input  logic [NUM_RULES-1:0]           cfg_rule_valid,
    input  logic [NUM_RULES-1:0]           cfg_rule_crit,
    input  logic [NUM_RULES*48-1:0]        cfg_rule_mac,
    input  logic [NUM_RULES*12-1:0]        cfg_rule_vid,
    input  logic [NUM_RULES*3-1:0]         cfg_rule_pcp,
    input  logic [NUM_RULES*PORT_W-1:0]    cfg_rule_port,
    input  logic [NUM_RULES*16-1:0]        cfg_rule_vlid,
    input  logic [NUM_RULES*NUM_PORTS-1:0] cfg_rule_dest,
    input  logic                           hdr_valid,
    input  logic [47:0]                    hdr_dmac,
    input  logic [11:0]                    hdr_vid,
    input  logic [2:0]                     hdr_pcp,
    input  logic [PORT_W-1:0]              hdr_port,
    input  logic [NUM_PORTS-1:0]           l2_dest,
    output logic                           res_valid,
    output logic                           res_hit,
    output logic [IDX_W-1:0]               res_idx,
    output logic                           res_critical,
    output logic [15:0]                    res_vlid,
    output logic [NUM_PORTS-1:0]           res_dest
);

    key_fmt_e               key_fmt;
    logic [NUM_RULES-1:0]   match;
    logic [NUM_RULES-1:0]   grant;
    logic [IDX_W-1:0]       win_idx;
    logic                   any_hit;
    logic                   win_crit;
    logic [VLID_W-1:0]      win_vlid;
    logic [NUM_PORTS-1:0]   win_dest;

    always_comb key_fmt = key_fmt_e'(cfg_key_fmt);

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        vlc_rule_match #(.PORT_W(PORT_W)) u_match (
            .key_fmt    (key_fmt),
            .mark_mask  (cfg_mark_mask),
            .mark_value (cfg_mark_value),
            .rule_valid (cfg_rule_valid[g]),
            .rule_mac   (cfg_rule_mac[g*MAC_W +: MAC_W]),
            .rule_vid   (cfg_rule_vid[g*VID_W +: VID_W]),
            .rule_pcp   (cfg_rule_pcp[g*PCP_W +: PCP_W]),
            .rule_port  (cfg_rule_port[g*PORT_W +: PORT_W]),
            .rule_vlid  (cfg_rule_vlid[g*VLID_W +: VLID_W]),
            .hdr_dmac   (hdr_dmac),
            .hdr_vid    (hdr_vid),
            .hdr_pcp    (hdr_pcp),
            .hdr_port   (hdr_port),
            .match_o    (match[g])
        );
    end

    vlc_prio_pick #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_pick (
        .match_i (match),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_hit)
    );

    always_comb begin
        win_crit = cfg_rule_crit[win_idx];
        win_vlid = cfg_rule_vlid[win_idx*VLID_W +: VLID_W];
        win_dest = cfg_rule_dest[win_idx*NUM_PORTS +: NUM_PORTS];
    end

    vlc_ctrl #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .key_fmt      (key_fmt),
        .any_hit      (any_hit),
        .win_idx      (win_idx),
        .win_crit     (win_crit),
        .win_vlid     (win_vlid),
        .win_dest     (win_dest),
        .l2_dest      (l2_dest),
        .res_valid    (res_valid),
        .res_hit      (res_hit),
        .res_idx      (res_idx),
        .res_critical (res_critical),
        .res_vlid     (res_vlid),
        .res_dest     (res_dest)
    );

    // Winner is a matching rule and no lower-numbered rule matched.
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (((grant & ~match) == '0) &&
                       (((grant - 1'b1) & match) == '0)));
    assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((match & ~cfg_rule_valid) == '0));

endmodule

// File: tb/sim_vl_classifier.sv
`timescale 1ns/1ps
module sim_vl_classifier;

    localparam int NR = 16;
    localparam int NP = 5;
    localparam int PW = 3;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_key_fmt = 1'b0;
    logic [31:0]     cfg_mark_mask = 32'hFFFF_FF00;
    logic [31:0]     cfg_mark_value = 32'h0A00_0000;
    logic [NR-1:0]   cfg_rule_valid = '0;
    logic [NR-1:0]   cfg_rule_crit = '0;
    logic [NR*48-1:0] cfg_rule_mac = '0;
    logic [NR*12-1:0] cfg_rule_vid = '0;
    logic [NR*3-1:0]  cfg_rule_pcp = '0;
    logic [NR*PW-1:0] cfg_rule_port = '0;
    logic [NR*16-1:0] cfg_rule_vlid = '0;
    logic [NR*NP-1:0] cfg_rule_dest = '0;
    logic            hdr_valid = 1'b0;
    logic [47:0]     hdr_dmac = '0;
    logic [11:0]     hdr_vid = '0;
    logic [2:0]      hdr_pcp = '0;
    logic [PW-1:0]   hdr_port = '0;
    logic [NP-1:0]   l2_dest = '0;
    logic            res_valid, res_hit, res_critical;
    logic [IW-1:0]   res_idx;
    logic [15:0]     res_vlid;
    logic [NP-1:0]   res_dest;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vl_classifier #(.NUM_RULES(NR), .NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_key_fmt(cfg_key_fmt),
        .cfg_mark_mask(cfg_mark_mask), .cfg_mark_value(cfg_mark_value),
        .cfg_rule_valid(cfg_rule_valid), .cfg_rule_crit(cfg_rule_crit),
        .cfg_rule_mac(cfg_rule_mac), .cfg_rule_vid(cfg_rule_vid),
        .cfg_rule_pcp(cfg_rule_pcp), .cfg_rule_port(cfg_rule_port),
        .cfg_rule_vlid(cfg_rule_vlid), .cfg_rule_dest(cfg_rule_dest),
        .hdr_valid(hdr_valid), .hdr_dmac(hdr_dmac), .hdr_vid(hdr_vid),
        .hdr_pcp(hdr_pcp), .hdr_port(hdr_port), .l2_dest(l2_dest),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_critical(res_critical), .res_vlid(res_vlid), .res_dest(res_dest)
    );

    typedef struct packed {
        logic        fmt;
        logic [47:0] mac;
        logic [11:0] vid;
        logic [2:0]  pcp;
        logic [2:0]  port;
        logic [4:0]  l2;
        logic        hit;
        logic [3:0]  idx;
        logic        crit;
        logic [15:0] vlid;
        logic [4:0]  dest;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // exact format: trap rule 0 and single-field misses (R2, R7, R6)
        '{1'b0, 48'h0102_0304_0506, 12'd100, 3'd7, 3'd3, 5'b00010, 1'b1, 4'd0, 1'b0, 16'h0000, 5'b10000, 8'd7},
        '{1'b0, 48'h0102_0304_0506, 12'd100, 3'd6, 3'd3, 5'b00010, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00010, 8'd2},
        '{1'b0, 48'h0102_0304_0506, 12'd100, 3'd7, 3'd2, 5'b00010, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00010, 8'd2},
        '{1'b0, 48'h0102_0304_0506, 12'd101, 3'd7, 3'd3, 5'b00010, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00010, 8'd2},
        '{1'b0, 48'h0102_0304_0507, 12'd100, 3'd7, 3'd3, 5'b00110, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00110, 8'd6},
        // exact format handoff: VL ID is the index (R8)
        '{1'b0, 48'h0A00_0000_0011, 12'd5,   3'd2, 3'd1, 5'b00001, 1'b1, 4'd1, 1'b1, 16'h0001, 5'b00000, 8'd8},
        // disabled rule 2 (R4)
        '{1'b0, 48'h0A00_0000_0022, 12'd5,   3'd2, 3'd1, 5'b00011, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00011, 8'd4},
        // rules 3 and 4 share a key: lowest wins (R5)
        '{1'b0, 48'h0A00_0000_0033, 12'd7,   3'd0, 3'd2, 5'b01000, 1'b1, 4'd3, 1'b0, 16'h0000, 5'b00001, 8'd5},
        '{1'b0, 48'h0B00_0000_0055, 12'd9,   3'd1, 3'd0, 5'b00001, 1'b1, 4'd5, 1'b1, 16'h0005, 5'b00000, 8'd8},
        // all-zero frame equals every disabled zero rule (R4)
        '{1'b0, 48'h0000_0000_0000, 12'd0,   3'd0, 3'd0, 5'b01010, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b01010, 8'd4},
        // marker format (R3, R9)
        '{1'b1, 48'h0A00_00AB_0055, 12'd0,   3'd0, 3'd0, 5'b00001, 1'b1, 4'd5, 1'b1, 16'h0055, 5'b00000, 8'd9},
        '{1'b1, 48'h0A00_0000_0011, 12'd999, 3'd3, 3'd1, 5'b00001, 1'b1, 4'd1, 1'b1, 16'h0011, 5'b00000, 8'd3},
        '{1'b1, 48'h0A00_0000_0033, 12'd0,   3'd0, 3'd2, 5'b00001, 1'b1, 4'd3, 1'b1, 16'h0033, 5'b00000, 8'd9},
        '{1'b1, 48'h0A00_0000_0011, 12'd5,   3'd2, 3'd2, 5'b00100, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00100, 8'd3},
        '{1'b1, 48'h0C00_0000_0055, 12'd0,   3'd0, 3'd0, 5'b00100, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00100, 8'd3},
        '{1'b1, 48'h0A00_0000_0022, 12'd5,   3'd2, 3'd1, 5'b10001, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b10001, 8'd4},
        '{1'b1, 48'h0102_0304_0506, 12'd100, 3'd7, 3'd3, 5'b00010, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b00010, 8'd3},
        '{1'b1, 48'h0A00_0000_0000, 12'd0,   3'd0, 3'd0, 5'b11000, 1'b0, 4'd0, 1'b0, 16'h0000, 5'b11000, 8'd4}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_rule(input int i, input logic v, input logic c, input logic [47:0] mac,
                            input logic [11:0] vid, input logic [2:0] pcp, input logic [2:0] port,
                            input logic [4:0] dest);
        cfg_rule_valid[i]          = v;
        cfg_rule_crit[i]           = c;
        cfg_rule_mac[i*48 +: 48]   = mac;
        cfg_rule_vid[i*12 +: 12]   = vid;
        cfg_rule_pcp[i*3 +: 3]     = pcp;
        cfg_rule_port[i*PW +: PW]  = port;
        cfg_rule_vlid[i*16 +: 16]  = mac[15:0];
        cfg_rule_dest[i*NP +: NP]  = dest;
    endtask

    task automatic drive(input vec_t v);
        cfg_key_fmt = v.fmt;
        hdr_dmac    = v.mac;
        hdr_vid     = v.vid;
        hdr_pcp     = v.pcp;
        hdr_port    = v.port;
        l2_dest     = v.l2;
        hdr_valid   = 1'b1;
    endtask

    task automatic expect_result(input vec_t v, input int n);
        string tag;
        tag = $sformatf("R%0d vec%0d", v.req, n);
        check({tag, " valid"}, 64'(res_valid), 64'd1);
        check({tag, " hit"},   64'(res_hit), 64'(v.hit));
        check({tag, " idx"},   64'(res_idx), 64'(v.idx));
        check({tag, " crit"},  64'(res_critical), 64'(v.crit));
        check({tag, " vlid"},  64'(res_vlid), 64'(v.vlid));
        check({tag, " dest"},  64'(res_dest), 64'(v.dest));
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_rule(0, 1'b1, 1'b0, 48'h0102_0304_0506, 12'd100, 3'd7, 3'd3, 5'b10000);
        set_rule(1, 1'b1, 1'b1, 48'h0A00_0000_0011, 12'd5,   3'd2, 3'd1, 5'b00100);
        set_rule(2, 1'b0, 1'b0, 48'h0A00_0000_0022, 12'd5,   3'd2, 3'd1, 5'b00001);
        set_rule(3, 1'b1, 1'b0, 48'h0A00_0000_0033, 12'd7,   3'd0, 3'd2, 5'b00001);
        set_rule(4, 1'b1, 1'b1, 48'h0A00_0000_0033, 12'd7,   3'd0, 3'd2, 5'b00010);
        set_rule(5, 1'b1, 1'b1, 48'h0B00_0000_0055, 12'd9,   3'd1, 3'd0, 5'b01000);
        cfg_rule_vlid[5*16 +: 16] = 16'h0055;

        // R10: reset state, with a strobe held during reset
        hdr_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 valid", 64'(res_valid), 64'd0);
        check("R10 hit",   64'(res_hit), 64'd0);
        check("R10 idx",   64'(res_idx), 64'd0);
        check("R10 crit",  64'(res_critical), 64'd0);
        check("R10 vlid",  64'(res_vlid), 64'd0);
        check("R10 dest",  64'(res_dest), 64'd0);
        hdr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", 64'(res_valid), 64'd0);

        for (int n = 0; n < NV; n++) begin
            drive(VECS[n]);
            @(negedge clk);
            hdr_valid = 1'b0;
            expect_result(VECS[n], n);
            @(negedge clk);
            check($sformatf("R1 pulse end vec%0d", n), 64'(res_valid), 64'd0);
        end

        // R1: back-to-back strobes, exact format
        drive(VECS[0]);
        @(negedge clk);
        expect_result(VECS[0], 100);
        drive(VECS[5]);
        @(negedge clk);
        hdr_valid = 1'b0;
        expect_result(VECS[5], 101);
        @(negedge clk);
        check("R1 idle after burst", 64'(res_valid), 64'd0);
        // R1: no result without a strobe, outputs hold
        repeat (3) @(negedge clk);
        check("R1 quiet valid", 64'(res_valid), 64'd0);

        // R7 trap: same frame with L2 bitmap pointing elsewhere still goes to CPU only
        drive('{1'b0, 48'h0102_0304_0506, 12'd100, 3'd7, 3'd3, 5'b01111,
                1'b1, 4'd0, 1'b0, 16'h0, 5'b10000, 8'd7});
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R7 trap dest", 64'(res_dest), 64'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule